// File: doc/BRIEF.md
# Shared-Pin GPIO Port

This block is an eight-pin general-purpose port with an output latch and a per-pin direction register, both written and read over a simple byte-wide register bus. Four of its pins are also used by on-chip peripherals. One pin carries serial transmit data and one carries serial receive data. The other two are timer capture/compare channel pins. When a peripheral claims a pin, that peripheral sets the pin's driver enable and driven level, and the direction bit no longer affects the pin.

Each pad appears as three separate signals: an output enable, an output level and an input level. The input levels pass through a two-flop synchronizer. The synchronized levels are returned on port reads and handed to the serial receiver and the timer channels.

When the port register is read, the direction bit of each pin selects the returned value. A set direction bit returns the latch bit and a clear one returns the synchronized pin level. This rule holds even on pins a peripheral has claimed. Software can load the latch while a pin is still an input, so the pin drives the intended level in the same cycle its driver turns on.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register and the output latch are all zero, every output enable is low, every output level is low and the read bus returns zero.
- R2: A bus write to address 0x0C loads the direction register. A 1 in a bit turns on that pin's driver in the next cycle unless a peripheral owns the pin. Reading 0x0C returns the register.
- R3: A bus write to address 0x08 loads the output latch. A non-owned pin's output level equals its latch bit whether or not its driver is on. A pin whose direction changes from 0 to 1 therefore drives the latched value in the first cycle its enable is high.
- R4: A read of address 0x08 returns, in the cycle after the read strobe, the latch bit for each pin whose direction bit is 1 and the synchronized pin level for each pin whose direction bit is 0. Reads of any other address return zero.
- R5: A pad input change reaches the read path and the peripheral inputs after exactly two rising clock edges.
- R6: While the serial enable input is high, pin 0 is driven with the serial transmit level and pin 1 has its driver off, whatever their direction bits say. When the serial enable is low, both pins follow the direction register and the latch.
- R7: Timer channel k (k = 0, 1) owns pin 2+k whenever its 2-bit mode field, bits [2k+1:2k] of the mode input, is not 00. While it owns the pin, the pin's enable and level come from that channel's output enable and output level. With mode 00 the pin is general-purpose.
- R8: On peripheral-owned pins the direction bit still selects latch or pin level in port reads.
- R9: The serial receive output and the timer channel inputs carry the synchronized levels of pins 1, 2 and 3 at all times, independent of ownership.
- R10: Writes to addresses other than 0x08 and 0x0C change no state, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register bus address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid the cycle after the read strobe |
| padIn | input | 8 | Pad input levels |
| padOutEn | output | 8 | Pad driver enables |
| padOut | output | 8 | Pad driven levels |
| serEnable | input | 1 | Serial function enable, claims pins 0 and 1 |
| serTxData | input | 1 | Serial transmit level for pin 0 |
| serRxData | output | 1 | Synchronized level of pin 1 |
| timMode | input | 4 | Mode field per timer channel, 2 bits each |
| timOutEn | input | 2 | Timer channel driver enables |
| timOutVal | input | 2 | Timer channel driven levels |
| timIn | output | 2 | Synchronized levels of pins 2 and 3 |

## Verification
The block has three latencies. A register write shows on the pad enables and levels in the cycle after its strobe. Peripheral controls reach the pads combinationally in the same cycle. Read data appears one cycle after the read strobe, and a pad change becomes visible after two rising edges. The bench drives inputs on falling edges. It samples pad outputs at the falling edge that follows the write edge. It samples read data at the falling edge after the read strobe, and checks synchronized levels only after two full cycles. One targeted check confirms that the serial receive output still holds the old level after one edge and the new level after the second.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Decoded register-bus actions handed from control to datapath.
  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic rdPort;
    logic rdDir;
  } regStrobes_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h0C
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobes_t       strobes
);

  logic hitData;
  logic hitDir;

  assign hitData = (busAddr == DATA_ADDR);
  assign hitDir  = (busAddr == DIR_ADDR);

  always_comb begin
    strobes         = '0;
    strobes.wrLatch = busWrEn && hitData;
    strobes.wrDir   = busWrEn && hitDir;
    strobes.rdPort  = busRdEn && hitData;
    strobes.rdDir   = busRdEn && hitDir;
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [PORT_W-1:0] busWrData,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] latchQ,
  output logic [PORT_W-1:0] dirQ,
  output logic [PORT_W-1:0] syncIn,
  output logic [PORT_W-1:0] busRdData
);

  logic [PORT_W-1:0] syncStage [SYNC_STAGES];
  logic [PORT_W-1:0] portView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
    end else begin
      if (strobes.wrLatch) latchQ <= busWrData;
      if (strobes.wrDir)   dirQ   <= busWrData;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncStage[s] <= '0;
        end else begin
          if (s == 0) syncStage[s] <= padIn;
          else        syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncIn   = syncStage[SYNC_STAGES-1];
  assign portView = (dirQ & latchQ) | (~dirQ & syncIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (strobes.rdPort) begin
      busRdData <= portView;
    end else if (strobes.rdDir) begin
      busRdData <= dirQ;
    end else begin
      busRdData <= '0;
    end
  end

endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
  parameter int PORT_W   = 8,
  parameter int TX_BIT   = 0,
  parameter int RX_BIT   = 1,
  parameter int TIM_BASE = 2,
  parameter int TIM_CH   = 2
) (
  input  logic [PORT_W-1:0]   latchQ,
  input  logic [PORT_W-1:0]   dirQ,
  input  logic [PORT_W-1:0]   syncIn,
  input  logic                serEnable,
  input  logic                serTxData,
  input  logic [2*TIM_CH-1:0] timMode,
  input  logic [TIM_CH-1:0]   timOutEn,
  input  logic [TIM_CH-1:0]   timOutVal,
  output logic [PORT_W-1:0]   padOutEn,
  output logic [PORT_W-1:0]   padOut,
  output logic                serRxData,
  output logic [TIM_CH-1:0]   timIn
);

  generate
    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
      logic owned;
      logic periOe;
      logic periVal;
      if (p == TX_BIT) begin : g_tx
        assign owned   = serEnable;
        assign periOe  = 1'b1;
        assign periVal = serTxData;
      end else if (p == RX_BIT) begin : g_rx
        assign owned   = serEnable;
        assign periOe  = 1'b0;
        assign periVal = latchQ[p];
      end else if (p >= TIM_BASE && p < TIM_BASE + TIM_CH) begin : g_tim
        localparam int CH = p - TIM_BASE;
        assign owned   = |timMode[2*CH +: 2];
        assign periOe  = timOutEn[CH];
        assign periVal = timOutVal[CH];
      end else begin : g_gpio
        assign owned   = 1'b0;
        assign periOe  = 1'b0;
        assign periVal = 1'b0;
      end
      assign padOutEn[p] = owned ? periOe  : dirQ[p];
      assign padOut[p]   = owned ? periVal : latchQ[p];
    end

    for (genvar c = 0; c < TIM_CH; c++) begin : g_timIn
      assign timIn[c] = syncIn[TIM_BASE + c];
    end
  endgenerate

  assign serRxData = syncIn[RX_BIT];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TX_BIT      = 0,
  parameter int RX_BIT      = 1,
  parameter int TIM_BASE    = 2,
  parameter int TIM_CH      = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h0C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [PORT_W-1:0]   busWrData,
  output logic [PORT_W-1:0]   busRdData,
  input  logic [PORT_W-1:0]   padIn,
  output logic [PORT_W-1:0]   padOutEn,
  output logic [PORT_W-1:0]   padOut,
  input  logic                serEnable,
  input  logic                serTxData,
  output logic                serRxData,
  input  logic [2*TIM_CH-1:0] timMode,
  input  logic [TIM_CH-1:0]   timOutEn,
  input  logic [TIM_CH-1:0]   timOutVal,
  output logic [TIM_CH-1:0]   timIn
);

  regStrobes_t       strobes;
  logic [PORT_W-1:0] latchQ;
  logic [PORT_W-1:0] dirQ;
  logic [PORT_W-1:0] syncIn;

  gpio_port_ctrl #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
  ) ctrl_i (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .strobes(strobes)
  );

  gpio_port_datapath #(
    .PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .padIn(padIn), .latchQ(latchQ), .dirQ(dirQ), .syncIn(syncIn),
    .busRdData(busRdData)
  );

  gpio_port_pinmux #(
    .PORT_W(PORT_W), .TX_BIT(TX_BIT), .RX_BIT(RX_BIT),
    .TIM_BASE(TIM_BASE), .TIM_CH(TIM_CH)
  ) mux_i (
    .latchQ(latchQ), .dirQ(dirQ), .syncIn(syncIn),
    .serEnable(serEnable), .serTxData(serTxData),
    .timMode(timMode), .timOutEn(timOutEn), .timOutVal(timOutVal),
    .padOutEn(padOutEn), .padOut(padOut), .serRxData(serRxData), .timIn(timIn)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PORT_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int TX_BIT   = 0,
  parameter int RX_BIT   = 1,
  parameter int TIM_BASE = 2,
  parameter int TIM_CH   = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h0C
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic                busRdEn,
  input logic [PORT_W-1:0]   busWrData,
  input logic [PORT_W-1:0]   busRdData,
  input logic [PORT_W-1:0]   padIn,
  input logic [PORT_W-1:0]   padOutEn,
  input logic [PORT_W-1:0]   padOut,
  input logic                serEnable,
  input logic                serTxData,
  input logic                serRxData,
  input logic [2*TIM_CH-1:0] timMode,
  input logic [TIM_CH-1:0]   timOutEn
);

  localparam int FREE_LO = TIM_BASE + TIM_CH;

  logic [1:0] sinceReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  // R6
  ser_tx_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    serEnable |-> (padOutEn[TX_BIT] && padOut[TX_BIT] == serTxData));

  // R6
  ser_rx_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    serEnable |-> !padOutEn[RX_BIT]);

  // R7
  tim_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timMode[1:0] != 2'b00) |-> (padOutEn[TIM_BASE] == timOutEn[0]));

  // R5
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd3) |-> (serRxData == $past(padIn[RX_BIT], 2)));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == DIR_ADDR) |=>
      (padOutEn[PORT_W-1:FREE_LO] == $past(busWrData[PORT_W-1:FREE_LO])));

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == DATA_ADDR) |=>
      (padOut[PORT_W-1:FREE_LO] == $past(busWrData[PORT_W-1:FREE_LO])));

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && (busAddr == DATA_ADDR || busAddr == DIR_ADDR)) |=>
      ($stable(padOut[PORT_W-1:FREE_LO]) && $stable(padOutEn[PORT_W-1:FREE_LO])));

  // R4
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr != DATA_ADDR && busAddr != DIR_ADDR) |=> (busRdData == '0));

endmodule

bind gpio_port gpio_port_chk #(
  .PORT_W(PORT_W), .ADDR_W(ADDR_W), .TX_BIT(TX_BIT), .RX_BIT(RX_BIT),
  .TIM_BASE(TIM_BASE), .TIM_CH(TIM_CH), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
) chk_i (.*);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] padIn = 8'hA5;
  logic [7:0] padOutEn;
  logic [7:0] padOut;
  logic       serEnable = 1'b0;
  logic       serTxData = 1'b0;
  logic       serRxData;
  logic [3:0] timMode = '0;
  logic [1:0] timOutEn = '0;
  logic [1:0] timOutVal = '0;
  logic [1:0] timIn;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn), .padOutEn(padOutEn),
    .padOut(padOut), .serEnable(serEnable), .serTxData(serTxData), .serRxData(serRxData),
    .timMode(timMode), .timOutEn(timOutEn), .timOutVal(timOutVal), .timIn(timIn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] holdEn;
    logic [7:0] holdOut;
    logic [7:0] holdRd;

    // R1 reset state
    waitCycles(3);
    check("R1 outEn", padOutEn, 8'h00);
    check("R1 out", padOut, 8'h00);
    check("R1 rdData", busRdData, 8'h00);
    rstN = 1'b1;
    waitCycles(3);
    busRead(8'h0C, rd); check("R1 dir", rd, 8'h00);
    busRead(8'h08, rd); check("R4 pins after reset", rd, 8'hA5);

    // R3 latch loaded while input, drives at once on enable
    busWrite(8'h08, 8'h5A);
    check("R3 out while input", padOut, 8'h5A);
    check("R3 outEn still off", padOutEn, 8'h00);
    busWrite(8'h0C, 8'hFF);
    check("R3 enable first cycle", padOutEn, 8'hFF);
    check("R3 level first cycle", padOut, 8'h5A);

    // R2 R4 sweep of every direction value
    for (int d = 0; d < 256; d++) begin
      busWrite(8'h08, 8'(d) ^ 8'h3C);
      busWrite(8'h0C, 8'(d));
      padIn = ~8'(d);
      waitCycles(2);
      check("R2 outEn", padOutEn, 8'(d));
      busRead(8'h08, rd);
      check("R4 port read", rd, (8'(d) & (8'(d) ^ 8'h3C)) | (~8'(d) & ~8'(d)));
      busRead(8'h0C, rd);
      check("R2 dir read", rd, 8'(d));
    end

    // R6 serial ownership
    busWrite(8'h0C, 8'h02);
    busWrite(8'h08, 8'h03);
    serEnable = 1'b1; serTxData = 1'b1;
    #1;
    check("R6 enables", {6'b0, padOutEn[1:0]}, 8'h01);
    check("R6 tx high", {7'b0, padOut[0]}, 8'h01);
    serTxData = 1'b0;
    #1;
    check("R6 tx low", {7'b0, padOut[0]}, 8'h00);
    busWrite(8'h0C, 8'h01);
    check("R6 dir ignored", {6'b0, padOutEn[1:0]}, 8'h01);

    // R8 read selection on owned pins
    padIn = 8'h02;
    waitCycles(2);
    busRead(8'h08, rd); check("R8 owned read a", {6'b0, rd[1:0]}, 8'h03);
    padIn = 8'h00;
    waitCycles(2);
    busRead(8'h08, rd); check("R8 owned read b", {6'b0, rd[1:0]}, 8'h01);

    // R5 R9 two-edge synchronizer on receive pin
    @(negedge clk); padIn = 8'h02;
    @(negedge clk); check("R5 after one edge", {7'b0, serRxData}, 8'h00);
    @(negedge clk); check("R5 R9 after two edges", {7'b0, serRxData}, 8'h01);

    serEnable = 1'b0;
    busWrite(8'h0C, 8'h02);
    check("R6 released enables", {6'b0, padOutEn[1:0]}, 8'h02);
    check("R6 released level", {6'b0, padOut[1:0]}, 8'h03);

    // R7 timer channel ownership sweep
    busWrite(8'h0C, 8'h0C);
    busWrite(8'h08, 8'h00);
    for (int ch = 0; ch < 2; ch++) begin
      for (int m = 0; m < 4; m++) begin
        for (int v = 0; v < 4; v++) begin
          @(negedge clk);
          timMode = '0; timMode[2*ch +: 2] = 2'(m);
          timOutEn = '0; timOutEn[ch] = v[1];
          timOutVal = '0; timOutVal[ch] = v[0];
          #1;
          check("R7 tim outEn", {7'b0, padOutEn[2+ch]}, (m != 0) ? {7'b0, v[1]} : 8'h01);
          check("R7 tim level", {7'b0, padOut[2+ch]}, (m != 0) ? {7'b0, v[0]} : 8'h00);
        end
      end
    end
    @(negedge clk); timMode = 4'b0101; padIn = 8'h04;
    waitCycles(2);
    check("R9 timer inputs", {6'b0, timIn}, 8'h01);
    busWrite(8'h0C, 8'h00);
    busRead(8'h08, rd); check("R8 timer pin read", {4'b0, rd[3:0]}, 8'h04);
    timMode = '0;

    // R10 unmapped writes and reads leave state alone
    busWrite(8'h0C, 8'hF0);
    busWrite(8'h08, 8'hA0);
    holdEn = padOutEn; holdOut = padOut;
    busRead(8'h08, holdRd);
    busWrite(8'h04, 8'hFF);
    busWrite(8'h09, 8'h0F);
    busWrite(8'h00, 8'h55);
    check("R10 outEn kept", padOutEn, holdEn);
    check("R10 out kept", padOut, holdOut);
    busRead(8'h04, rd); check("R4 R10 unmapped read", rd, 8'h00);
    busRead(8'h08, rd); check("R10 port read kept", rd, holdRd);
    busRead(8'h08, rd); check("R10 repeat read", rd, holdRd);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule